// File: doc/BRIEF.md
# Burst Address Counter Port

This block generates the address that one port of a dual-port memory uses for each access. Every rising clock edge it samples an external address bus and three active-low controls: clear, load strobe and step enable. From these it forms a registered access address for the next cycle. The address is either the freshly sampled external address, or the value held by an internal binary counter that can be cleared, held or advanced by one. A burst can therefore be started with a single load and continued with step cycles, and the external bus is not needed while the burst runs.

An access-valid input is registered alongside the address, so the access flag and its address arrive at the array side together, one cycle after the controls are sampled. The counter controls do not depend on the access-valid input, so the address can be preset while the port is idle. A clear costs no extra cycle: an access sampled in the same cycle as a clear goes ahead and uses address 0.

Top module: `burst_addr_port`

## Requirements
- R1: While `rst_n` is low, `acc_addr` is 0 and `acc_go` is 0.
- R2: When `zero_n` is sampled low on a rising edge, `acc_addr` is 0 after that edge, whatever the values of `strobe_n`, `step_n` and `ext_addr`.
- R3: When `zero_n` is high and `strobe_n` is sampled low, `acc_addr` after the edge equals the `ext_addr` value sampled at that edge.
- R4: When `zero_n` and `strobe_n` are high and `step_n` is sampled low, `acc_addr` after the edge is its previous value plus one.
- R5: When `zero_n`, `strobe_n` and `step_n` are all high, `acc_addr` keeps its value and the value on `ext_addr` has no effect on it.
- R6: A step from the all-ones address (2**AW-1) gives address 0.
- R7: `acc_go` after each edge equals the `acc_req` value sampled at that edge, including an edge where `zero_n` is low, so an access in a clear cycle proceeds with address 0 and no dead cycle.
- R8: A step right after a load gives the loaded address plus one, so no location is skipped.
- R9: The clear, load, step and hold controls act the same way when `acc_req` is low as when it is high.
- R10: With `strobe_n` low on consecutive edges, each edge loads a new, arbitrary external address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the port |
| ext_addr | input | AW | External address bus |
| strobe_n | input | 1 | Active-low load strobe: use and load the external address |
| step_n | input | 1 | Active-low step enable: advance the counter by one |
| zero_n | input | 1 | Active-low clear: set the address to 0; highest priority |
| acc_req | input | 1 | Access requested in this cycle |
| acc_addr | output | AW | Address of the current access |
| acc_go | output | 1 | Registered access flag that goes with `acc_addr` |

## Verification
The functions that can fall in one cycle are a clear and an access: the bench raises `zero_n` low together with `acc_req` high, and also together with a low `strobe_n` and `step_n`, then expects address 0 with `acc_go` high on the following cycle. A behavioural model in the bench applies the clear, load, step, hold priority to each sampled set of controls and is compared with both outputs after every edge, so a wrong priority or a lost access shows as a mismatch in that very cycle.

// File: rtl/burst_addr_port.sv
module burst_addr_port #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          step_n,
  input  logic          zero_n,
  input  logic          acc_req,
  output logic [AW-1:0] acc_addr,
  output logic          acc_go
);

  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] ZERO = '0;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          go_q;

  always_comb begin
    if (!zero_n)        addr_d = ZERO;
    else if (!strobe_n) addr_d = ext_addr;
    else if (!step_n)   addr_d = addr_q + ONE;
    else                addr_d = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= ZERO;
      go_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      go_q   <= acc_req;
    end
  end

  assign acc_addr = addr_q;
  assign acc_go   = go_q;

  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (acc_addr == ZERO && !acc_go);
    end
  end

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> acc_addr == ZERO);

  assert_load_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zero_n && !strobe_n |=> acc_addr == $past(ext_addr));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_n && strobe_n && !step_n |=> acc_addr == $past(acc_addr) + ONE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_n && strobe_n && step_n |=> $stable(acc_addr));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_n && strobe_n && !step_n && (&acc_addr) |=> acc_addr == ZERO);

  assert_go_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> acc_go);

  assert_go_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> !acc_go);

endmodule

// File: tb/burst_addr_port_tb.sv
`timescale 1ns/1ps
module burst_addr_port_tb;
  localparam int AW = 15;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] ext_addr;
  logic strobe_n, step_n, zero_n, acc_req;
  logic [AW-1:0] acc_addr;
  logic acc_go;

  int checks = 0;
  int errors = 0;
  int exp_addr = 0;
  bit exp_go = 1'b0;

  always #2 clk = ~clk;

  burst_addr_port #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .step_n(step_n), .zero_n(zero_n), .acc_req(acc_req),
    .acc_addr(acc_addr), .acc_go(acc_go)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit z, input bit s, input bit t,
                      input bit r, input int ea);
    zero_n = z; strobe_n = s; step_n = t; acc_req = r; ext_addr = AW'(ea);
    @(posedge clk);
    if (!z)      exp_addr = 0;
    else if (!s) exp_addr = ea & MASK;
    else if (!t) exp_addr = (exp_addr + 1) & MASK;
    exp_go = r;
    @(negedge clk);
    check({tag, " addr"}, int'(acc_addr), exp_addr);
    check({tag, " go"}, int'(acc_go), int'(exp_go));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; zero_n = 1'b1; strobe_n = 1'b0; step_n = 1'b0;
    acc_req = 1'b1; ext_addr = AW'(1234);
    repeat (3) @(negedge clk);
    check("R1 addr", int'(acc_addr), 0);
    check("R1 go", int'(acc_go), 0);
    rst_n = 1'b1;

    step("R3 load", 1, 0, 1, 1, 100);
    step("R4 step", 1, 1, 0, 1, 7);
    step("R4 step", 1, 1, 0, 0, 9);
    step("R5 hold", 1, 1, 1, 1, 5555);
    step("R5 hold", 1, 1, 1, 1, 0);
    step("R2 clear over load", 0, 0, 1, 1, 300);
    step("R3 load", 1, 0, 1, 1, 321);
    step("R2 clear over step", 0, 1, 0, 1, 9);
    step("R3 load", 1, 0, 0, 0, 77);
    step("R2 clear all low", 0, 0, 0, 1, 4000);
    step("R7 access in clear", 0, 1, 1, 1, 0);
    step("R7 no access", 1, 1, 1, 0, 0);
    step("R8 load", 1, 0, 1, 1, 2000);
    step("R8 step after load", 1, 1, 0, 1, 0);
    step("R8 step again", 1, 1, 0, 1, 0);
    step("R6 load max", 1, 0, 1, 1, MASK);
    step("R6 wrap", 1, 1, 0, 1, 3);
    step("R6 after wrap", 1, 1, 0, 1, 3);
    step("R9 load idle", 1, 0, 1, 0, 4321);
    step("R9 step idle", 1, 1, 0, 0, 1);
    step("R9 hold idle", 1, 1, 1, 0, 99);
    step("R9 clear idle", 0, 1, 1, 0, 99);
    for (int i = 0; i < 40; i++)
      step("R10 back-to-back load", 1, 0, i[0], 1, (i * 7919 + 13) & MASK);
    for (int i = 0; i < 60; i++) begin
      int code = (i * 37 + 11) % 16;
      step("R9 mixed", code[3] | code[2], code[1], code[0], code[2], (i * 4099) & MASK);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule